// File: doc/BRIEF.md
# Bus Access Width Adapter

The adapter connects a CPU-side port that issues byte, halfword or longword accesses in big-endian byte order to a register file in which every register has one fixed native width. It looks up that width for each four-byte group of the register window, then turns each CPU access into a short run of accesses at the native width. An access wider than the register is split into big-endian pieces. An access narrower than the register becomes a read of the containing register and an extraction of the addressed lane. On writes, the read is followed by a merged write-back.

The downstream register port carries one native-width access per cycle and returns read data in the same cycle. The CPU side sees one `ack_o` pulse after the last downstream access has finished. It sees one `err_o` pulse instead when the address falls outside the register window or the size code is invalid. The adapter holds no register contents of its own.

Top module: `bus_width_adapter`

## Requirements
- R1: After reset, `ack_o`, `err_o`, `busy_o` and `reg_req_o` are all low.
- R2: Only the low 10 address bits are used. If that reduced address is 0x200 or above, or if `size_i` is 3, `err_o` pulses for one cycle in the cycle after the request. In that case no downstream access is made and no `ack_o` is given.
- R3: Native width comes from a table entry selected by address bits 8:2. Entry code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. By default, group g has code g mod 3. Every downstream access uses the native width of its group. Size codes on both ports are 0 = byte, 1 = halfword, 2 = longword.
- R4: An access whose size equals the native width makes exactly one downstream access.
- R5: A byte read from a 2-byte register reads the aligned halfword. It returns bits 15:8 for an even address and bits 7:0 for an odd one.
- R6: A byte write to a 2-byte register reads the aligned halfword. It then writes it back with only the addressed byte replaced.
- R7: A halfword access to 1-byte registers makes two byte accesses. The lower address carries bits 15:8.
- R8: A longword access to narrower registers is split big-endian. For 2-byte registers it makes two halfword accesses, the lower address carrying bits 31:16. For 1-byte registers it makes four byte accesses.
- R9: A byte or halfword access to a 4-byte register uses the aligned longword. Offset 0 is the most significant lane. Writes are a read followed by a merged write.
- R10: `ack_o` rises in the cycle after the last downstream access and lasts one cycle. `rdata_o` carries the right-justified read value with it, and 0 for writes.
- R11: `req_i` is ignored while `busy_o` is high.
- R12: The address is aligned down to the access size, so the low bits below the size are ignored.
- R13: Downstream accesses run in consecutive cycles, one per cycle, starting in the cycle after acceptance. `reg_req_o` stays high until the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | CPU access request, sampled when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | CPU byte address |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Right-justified write data |
| busy_o | output | 1 | Access in progress |
| ack_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| rdata_o | output | 32 | Right-justified read data, valid with ack_o |
| reg_req_o | output | 1 | Downstream access this cycle |
| reg_we_o | output | 1 | Downstream write |
| reg_addr_o | output | 10 | Downstream byte address, aligned to its size |
| reg_size_o | output | 2 | Downstream size code |
| reg_wdata_o | output | 32 | Downstream right-justified write data |
| reg_rdata_i | input | 32 | Downstream right-justified read data, same cycle |

## Verification
A wrong step counter or operation count shows up at once as an extra or missing downstream access. It also moves `ack_o` to the wrong cycle, so it is caught on the access that causes it. A wrong lane shift or a stale read-modify-write holding value shows up as corrupted bytes next to the written lane. Those bytes are compared right after the write completes. A bad width lookup appears as a downstream size that does not match the group. This is flagged on the first access to the affected group.

// File: rtl/bwa_pkg.sv
package bwa_pkg;
  localparam int unsigned RED_W  = 10;
  localparam int unsigned SPAN   = 'h200;
  localparam int unsigned N_GRP  = SPAN / 4;
  localparam int unsigned GI_W   = $clog2(N_GRP);
  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  typedef struct packed {
    logic             err;
    logic [RED_W-1:0] base;
    logic [1:0]       s_lg;
    logic [1:0]       w_lg;
    logic             narrow;
    logic [2:0]       n_ops;
  } plan_t;

  function automatic logic [2*N_GRP-1:0] default_map();
    logic [2*N_GRP-1:0] m;
    m = '0;
    for (int g = 0; g < N_GRP; g++) m[2*g +: 2] = 2'(g % 3);
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] lane_mask(logic [1:0] lg);
    case (lg)
      2'd0:    return DATA_W'(32'h0000_00ff);
      2'd1:    return DATA_W'(32'h0000_ffff);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/bwa_decode.sv
module bwa_decode
  import bwa_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter logic [2*N_GRP-1:0] WIDTH_MAP = default_map()
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              we_i,
  output plan_t             plan_o
);
  logic [RED_W-1:0] red;
  logic             out_rng, bad_sz;
  logic [GI_W-1:0]  grp;
  logic [1:0]       code, w_lg, s_lg;
  logic [RED_W-1:0] s_mask;
  logic             unused_hi;

  assign unused_hi = ^addr_i[ADDR_W-1:RED_W];
  assign red     = addr_i[RED_W-1:0];
  assign out_rng = (red >= RED_W'(SPAN));
  assign bad_sz  = (size_i == SZ_BAD);
  assign grp     = red[2 +: GI_W];
  assign code    = WIDTH_MAP[2*grp +: 2];
  assign w_lg    = code[1] ? 2'd2 : code;
  assign s_lg    = bad_sz ? 2'd0 : size_i;
  assign s_mask  = RED_W'(2'b11 >> (2'd2 - s_lg));

  always_comb begin
    plan_o.err    = out_rng | bad_sz;
    plan_o.base   = red & ~s_mask;
    plan_o.s_lg   = s_lg;
    plan_o.w_lg   = w_lg;
    plan_o.narrow = (w_lg > s_lg);
    if (w_lg > s_lg) plan_o.n_ops = we_i ? 3'd2 : 3'd1;
    else             plan_o.n_ops = 3'd1 << (s_lg - w_lg);
  end
endmodule

// File: rtl/bwa_lane.sv
module bwa_lane
  import bwa_pkg::*;
(
  input  logic [1:0]        s_lg_i,
  input  logic [1:0]        w_lg_i,
  input  logic              narrow_i,
  input  logic [1:0]        off_i,
  input  logic [1:0]        step_i,
  input  logic [2:0]        n_ops_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] op_wdata_o,
  output logic [DATA_W-1:0] acc_next_o,
  output logic [DATA_W-1:0] result_o
);
  logic [DATA_W-1:0] mask_s, mask_w, merged;
  logic [2:0]        w_bytes, s_bytes, lane_byte, k_rev, sp_byte;
  logic [1:0]        off_in_w;
  logic [5:0]        lane_sh, sp_sh, acc_sh;

  assign mask_s    = lane_mask(s_lg_i);
  assign mask_w    = lane_mask(w_lg_i);
  assign w_bytes   = 3'd1 << w_lg_i;
  assign s_bytes   = 3'd1 << s_lg_i;
  assign off_in_w  = off_i & 2'(w_bytes - 3'd1);
  // lane position of the narrow value inside the register, MSB first
  assign lane_byte = w_bytes - s_bytes - {1'b0, off_in_w};
  assign lane_sh   = {lane_byte, 3'b000};
  // split piece k takes the k-th slice from the top
  assign k_rev     = n_ops_i - 3'd1 - {1'b0, step_i};
  assign sp_byte   = k_rev << w_lg_i;
  assign sp_sh     = {sp_byte, 3'b000};
  assign acc_sh    = 6'd8 << w_lg_i;

  assign merged     = (hold_i & ~(mask_s << lane_sh)) | ((wdata_i & mask_s) << lane_sh);
  assign op_wdata_o = narrow_i ? merged : ((wdata_i >> sp_sh) & mask_w);
  assign acc_next_o = (acc_i << acc_sh) | (rdata_i & mask_w);
  assign result_o   = narrow_i ? ((rdata_i >> lane_sh) & mask_s) : acc_next_o;
endmodule

// File: rtl/bwa_seq.sv
module bwa_seq
  import bwa_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  plan_t             plan_i,
  input  logic [DATA_W-1:0] op_wdata_i,
  input  logic [DATA_W-1:0] acc_next_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [RED_W-1:0]  reg_addr_o,
  output logic [1:0]        reg_size_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic [1:0]        s_lg_o,
  output logic [1:0]        w_lg_o,
  output logic              narrow_o,
  output logic [1:0]        off_o,
  output logic [1:0]        step_o,
  output logic [2:0]        n_ops_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] hold_o,
  output logic [DATA_W-1:0] acc_o
);
  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e               st_q;
  logic              we_q, narrow_q;
  logic [RED_W-1:0]  base_q;
  logic [1:0]        s_lg_q, w_lg_q, step_q;
  logic [2:0]        n_q;
  logic [DATA_W-1:0] wdata_q, hold_q, acc_q;
  logic              last;
  logic [RED_W-1:0]  w_mask;

  assign last   = ({1'b0, step_q} == (n_q - 3'd1));
  assign w_mask = RED_W'(2'b11 >> (2'd2 - w_lg_q));

  assign busy_o      = (st_q == ST_RUN);
  assign reg_req_o   = (st_q == ST_RUN);
  assign reg_we_o    = we_q & (~narrow_q | (step_q == 2'd1));
  assign reg_size_o  = w_lg_q;
  assign reg_wdata_o = op_wdata_i;
  assign reg_addr_o  = narrow_q ? (base_q & ~w_mask)
                                : (base_q + (RED_W'(step_q) << w_lg_q));

  assign s_lg_o   = s_lg_q;
  assign w_lg_o   = w_lg_q;
  assign narrow_o = narrow_q;
  assign off_o    = base_q[1:0];
  assign step_o   = step_q;
  assign n_ops_o  = n_q;
  assign wdata_o  = wdata_q;
  assign hold_o   = hold_q;
  assign acc_o    = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      we_q     <= 1'b0;
      narrow_q <= 1'b0;
      base_q   <= '0;
      s_lg_q   <= '0;
      w_lg_q   <= '0;
      step_q   <= '0;
      n_q      <= 3'd1;
      wdata_q  <= '0;
      hold_q   <= '0;
      acc_q    <= '0;
      ack_o    <= 1'b0;
      err_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      ack_o <= 1'b0;
      err_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            if (plan_i.err) begin
              err_o <= 1'b1;
            end else begin
              st_q     <= ST_RUN;
              we_q     <= we_i;
              narrow_q <= plan_i.narrow;
              base_q   <= plan_i.base;
              s_lg_q   <= plan_i.s_lg;
              w_lg_q   <= plan_i.w_lg;
              n_q      <= plan_i.n_ops;
              wdata_q  <= wdata_i;
              step_q   <= '0;
              acc_q    <= '0;
            end
          end
        end
        ST_RUN: begin
          if (narrow_q && step_q == 2'd0) hold_q <= reg_rdata_i;
          acc_q  <= acc_next_i;
          step_q <= step_q + 2'd1;
          if (last) begin
            st_q    <= ST_IDLE;
            ack_o   <= 1'b1;
            rdata_o <= we_q ? '0 : result_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 32,
  parameter logic [2*N_GRP-1:0] WIDTH_MAP = default_map()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              reg_req_o,
  output logic              reg_we_o,
  output logic [9:0]        reg_addr_o,
  output logic [1:0]        reg_size_o,
  output logic [31:0]       reg_wdata_o,
  input  logic [31:0]       reg_rdata_i
);
  plan_t             plan;
  logic [1:0]        s_lg, w_lg, off, step;
  logic              narrow;
  logic [2:0]        n_ops;
  logic [DATA_W-1:0] c_wdata, hold, acc, acc_next, op_wdata, result;

  bwa_decode #(.ADDR_W(ADDR_W), .WIDTH_MAP(WIDTH_MAP)) u_decode (
    .addr_i (addr_i),
    .size_i (size_i),
    .we_i   (we_i),
    .plan_o (plan)
  );

  bwa_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .plan_i      (plan),
    .op_wdata_i  (op_wdata),
    .acc_next_i  (acc_next),
    .result_i    (result),
    .reg_rdata_i (reg_rdata_i),
    .busy_o      (busy_o),
    .ack_o       (ack_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o),
    .reg_req_o   (reg_req_o),
    .reg_we_o    (reg_we_o),
    .reg_addr_o  (reg_addr_o),
    .reg_size_o  (reg_size_o),
    .reg_wdata_o (reg_wdata_o),
    .s_lg_o      (s_lg),
    .w_lg_o      (w_lg),
    .narrow_o    (narrow),
    .off_o       (off),
    .step_o      (step),
    .n_ops_o     (n_ops),
    .wdata_o     (c_wdata),
    .hold_o      (hold),
    .acc_o       (acc)
  );

  bwa_lane u_lane (
    .s_lg_i     (s_lg),
    .w_lg_i     (w_lg),
    .narrow_i   (narrow),
    .off_i      (off),
    .step_i     (step),
    .n_ops_i    (n_ops),
    .wdata_i    (c_wdata),
    .hold_i     (hold),
    .acc_i      (acc),
    .rdata_i    (reg_rdata_i),
    .op_wdata_o (op_wdata),
    .acc_next_o (acc_next),
    .result_o   (result)
  );
endmodule

// File: rtl/bwa_chk.sv
module bwa_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       ack_o,
  input logic       err_o,
  input logic       reg_req_o,
  input logic [9:0] reg_addr_o,
  input logic [1:0] reg_size_o
);
  // R2
  err_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!reg_req_o && !ack_o));

  // R10
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R10
  ack_after_ops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ($past(reg_req_o) && !reg_req_o));

  // R13
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reg_req_o) |-> ack_o);

  // R11
  start_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reg_req_o) |-> $past(req_i));

  // R2
  addr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (reg_addr_o < 10'h200));

  // R12
  op_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> ((reg_addr_o & (10'(2'b11) >> (2'd2 - reg_size_o))) == 10'd0));

  // R3
  op_size_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (reg_size_o != 2'd3));
endmodule

bind bus_width_adapter bwa_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ack_o      (ack_o),
  .err_o      (err_o),
  .reg_req_o  (reg_req_o),
  .reg_addr_o (reg_addr_o),
  .reg_size_o (reg_size_o)
);

// File: tb/bus_width_adapter_tb.sv
module bus_width_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [31:0] addr_i = '0, wdata_i = '0;
  logic [1:0]  size_i = '0;
  logic        busy_o, ack_o, err_o, reg_req_o, reg_we_o;
  logic [31:0] rdata_o, reg_wdata_o, reg_rdata_i;
  logic [9:0]  reg_addr_o;
  logic [1:0]  reg_size_o;

  int checks = 0, failures = 0;
  int op_total = 0, size_bad = 0;
  logic [7:0] mem  [512];
  logic [7:0] refm [512];

  // results of the last access
  int          l_cyc, l_ops, l_sbad;
  logic        l_ack, l_err;
  logic [31:0] l_rdata;

  always #4 clk = ~clk;

  bus_width_adapter u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .busy_o(busy_o), .ack_o(ack_o), .err_o(err_o),
    .rdata_o(rdata_o), .reg_req_o(reg_req_o), .reg_we_o(reg_we_o),
    .reg_addr_o(reg_addr_o), .reg_size_o(reg_size_o), .reg_wdata_o(reg_wdata_o),
    .reg_rdata_i(reg_rdata_i)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic int grp_w(int a);
    return (a >> 2) % 3;
  endfunction

  function automatic int exp_ops(int s, int w, logic we);
    if (w > s) return we ? 2 : 1;
    return 1 << (s - w);
  endfunction

  function automatic string tag_of(int s, int w, logic we);
    if (s == w) return "R4";
    if (s < w) begin
      if (w == 1) return we ? "R6" : "R5";
      return "R9";
    end
    return (s == 1) ? "R7" : "R8";
  endfunction

  // register file model on the downstream port
  always_comb begin
    reg_rdata_i = '0;
    for (int i = 0; i < 4; i++)
      if (i < (1 << reg_size_o))
        reg_rdata_i = (reg_rdata_i << 8) | 32'(mem[(int'(reg_addr_o) + i) & 511]);
  end

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_val(i);
    end else if (reg_req_o) begin
      op_total <= op_total + 1;
      if (int'(reg_size_o) != grp_w(int'(reg_addr_o))) size_bad <= size_bad + 1;
      if (reg_we_o) begin
        for (int i = 0; i < 4; i++)
          if (i < (1 << reg_size_o))
            mem[(int'(reg_addr_o) + i) & 511] <=
              8'(reg_wdata_o >> (8 * ((1 << reg_size_o) - 1 - i)));
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [1:0] sz, input logic [31:0] addr,
                        input logic [31:0] wd, input bit hold);
    int o0, b0;
    @(negedge clk);
    req_i = 1'b1; we_i = we; size_i = sz; addr_i = addr; wdata_i = wd;
    o0 = op_total; b0 = size_bad;
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      we_i = 1'b1; addr_i = 32'h0000_0100; size_i = 2'd2; wdata_i = 32'hdead_beef;
    end else req_i = 1'b0;
    l_cyc = 0;
    while (!ack_o && !err_o && l_cyc < 20) begin
      @(posedge clk);
      l_cyc++;
      @(negedge clk);
    end
    req_i = 1'b0;
    l_ack = ack_o; l_err = err_o; l_rdata = rdata_o;
    l_ops = op_total - o0; l_sbad = size_bad - b0;
  endtask

  task automatic run(input logic we, input logic [1:0] sz, input logic [31:0] addr,
                     input logic [31:0] wd, input bit hold);
    int red, a, w, s, n, mism;
    logic [31:0] exp;
    string t;
    access(we, sz, addr, wd, hold);
    red = int'(addr[9:0]);
    if (red >= 'h200 || sz == 2'd3) begin
      chk(l_err && !l_ack && l_ops == 0 && l_cyc == 0, "R2", "err/ops",
          {l_err, l_ack, 30'(l_ops)}, {1'b1, 1'b0, 30'd0});
      return;
    end
    s = int'(sz);
    a = red & ~((1 << s) - 1);
    w = grp_w(a);
    n = exp_ops(s, w, we);
    t = tag_of(s, w, we);
    chk(l_ack && !l_err, t, "ack", {30'd0, l_ack, l_err}, 32'd2);
    chk(l_ops == n, "R13", "op count", 32'(l_ops), 32'(n));
    chk(l_cyc == n, "R10", "ack latency", 32'(l_cyc), 32'(n));
    chk(l_sbad == 0, "R3", "op size vs group", 32'(l_sbad), 32'd0);
    if (we) begin
      for (int i = 0; i < (1 << s); i++)
        refm[a + i] = 8'(wd >> (8 * ((1 << s) - 1 - i)));
      mism = 0;
      for (int i = 0; i < 512; i++) if (mem[i] !== refm[i]) mism++;
      chk(mism == 0, t, "mem mismatches after write", 32'(mism), 32'd0);
      chk(l_rdata == 0, "R10", "rdata on write", l_rdata, 32'd0);
    end else begin
      exp = '0;
      for (int i = 0; i < (1 << s); i++) exp = (exp << 8) | 32'(refm[a + i]);
      chk(l_rdata == exp, t, "read data", l_rdata, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) refm[i] = init_val(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ack_o && !err_o && !busy_o && !reg_req_o, "R1", "reset outputs",
        {28'd0, ack_o, err_o, busy_o, reg_req_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (2) @(posedge clk);

    run(1'b0, 2'd0, 32'h004, '0, 1'b0);             // R5 even byte of halfword reg
    chk(l_rdata == 32'(refm[4]), "R5", "even lane", l_rdata, 32'(refm[4]));
    run(1'b0, 2'd0, 32'h005, '0, 1'b0);             // R5 odd byte
    run(1'b1, 2'd0, 32'h007, 32'h0000_00a5, 1'b0);  // R6
    run(1'b0, 2'd1, 32'h000, '0, 1'b0);             // R7
    run(1'b1, 2'd1, 32'h002, 32'h0000_1234, 1'b0);  // R7
    run(1'b1, 2'd2, 32'h004, 32'h89ab_cdef, 1'b0);  // R8 halves
    chk(mem[4] == 8'h89 && mem[6] == 8'hcd, "R8", "upper half at lower addr",
        {16'd0, mem[4], mem[6]}, 32'h89cd);
    run(1'b0, 2'd1, 32'h008, '0, 1'b0);             // R9 offset 0
    run(1'b0, 2'd1, 32'h00a, '0, 1'b0);             // R9 offset 2
    run(1'b1, 2'd1, 32'h00a, 32'h0000_5a5a, 1'b0);  // R9 rmw
    run(1'b1, 2'd0, 32'h009, 32'h0000_00c3, 1'b0);  // R9 byte into word
    run(1'b0, 2'd2, 32'h008, '0, 1'b0);             // R4
    run(1'b0, 2'd0, 32'h200, '0, 1'b0);             // R2 range
    run(1'b1, 2'd3, 32'h010, 32'h1, 1'b0);          // R2 bad size
    run(1'b0, 2'd2, 32'hffff_fc08, '0, 1'b0);       // R2 upper bits dropped
    run(1'b1, 2'd2, 32'h00c, 32'h0102_0304, 1'b1);  // R11 req held while busy
    chk(l_ops == 4 && mem['h100] == refm['h100], "R11", "ignored while busy",
        32'(l_ops), 32'd4);
    run(1'b0, 2'd2, 32'h00b, '0, 1'b0);             // R12 aligns to 0x08
    chk(l_ops == 1, "R12", "aligned longword", 32'(l_ops), 32'd1);

    for (int k = 0; k < 250; k++) begin
      logic [1:0]  sz;
      logic [31:0] ad;
      sz = 2'($urandom % 3);
      ad = ($urandom & 32'hffff_fc00) | ($urandom % 32'h200);
      if (k % 25 == 0) ad = ad | 32'h200;
      run(1'($urandom % 2), sz, ad, $urandom, 1'(k % 7 == 0));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule